// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block is the digital half of a 16-bit successive-approximation converter. A positive pulse on the convert-start input begins a conversion on its falling edge. The sequencer then raises a busy flag and releases a gated conversion clock that makes exactly seventeen rising edges. It drives a trial word to an external feedback DAC and resolves one bit per gated-clock edge, most significant bit first. Each decision comes from a single-bit comparator input.

The register is negative-true: a stored 0 means the bit is on. The trial word and the parallel result therefore read as the complement of the input code. That is complementary straight binary for unipolar ranges and complementary offset binary for bipolar ranges. A mode input inverts the result's MSB to give complementary two's complement. Busy falls one system clock after the final decision, so a downstream register can capture the result on the falling edge of busy. The gated clock is then held low until the next conversion.

Top module: `sar_seq_ctrl`

## Requirements
- R1: While reset is high and after it, before any conversion: busy is 0, gclk is 0, trial is all ones, and result is all ones (with twos_mode at 0).
- R2: A 1-to-0 transition of conv_start seen while idle sets busy at the next clock edge. The trial word is loaded with all ones at that edge, and gclk is 0.
- R3: Each conversion produces exactly 17 rising edges on gclk. The first comes HALF_DIV clocks after busy rises, and the edges are 2*HALF_DIV clocks apart.
- R4: On the first gclk rising edge, the trial word becomes MSB 0 and all other bits 1 (16'h7FFF at the default width).
- R5: On rising edge k (k = 1..16), bit index 16-k takes the value cmp_in had one clock before that edge. A 1 rejects the bit and a 0 keeps it. Bit index 15-k (when k < 16) is cleared. trial changes only on a gclk rising edge or when a conversion starts.
- R6: Busy falls one clock after the 17th rising edge, so busy stays high for 33*HALF_DIV+1 clocks. gclk is forced low at that edge and stays low while busy is 0.
- R7: A falling edge on conv_start while busy is high is ignored. The conversion keeps its length, its edge count and its result.
- R8: The result is unchanged in the clock before busy falls, and it holds its value after busy falls until the next conversion starts.
- R9: With a comparator that outputs 1 when the positive-true trial value (~trial) exceeds an input code V, the final result equals ~V. Examples: V=16'hFFFF gives 16'h0000, V=16'h0000 gives 16'hFFFF, and V=16'h8000 gives 16'h7FFF.
- R10: With twos_mode at 1, result bit 15 is inverted relative to the register, combinationally. For example, V=16'h8000 gives 16'hFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| conv_start | input | 1 | Convert-start pulse; the conversion begins on its falling edge |
| cmp_in | input | 1 | Comparator: 1 means the DAC output is above the analog input (reject) |
| twos_mode | input | 1 | 1 inverts the MSB of result (complementary two's complement) |
| trial | output | 16 | Negative-true trial word to the feedback DAC |
| busy | output | 1 | High while a conversion is in progress |
| gclk | output | 1 | Gated conversion clock, low when idle |
| result | output | 16 | Parallel result in complementary coding |

## Verification
The codes for both ends of the range test the all-keep and all-reject decision chains. Mid-scale and the codes next to it show whether the MSB decision is separated correctly from the lower bits. Irregular patterns such as 16'hA5C3 expose a wrong bit index or a wrong clearing order, which the per-edge trial checks locate exactly. Conversions with twos_mode set, and a mode flip after a conversion, separate MSB inversion from register contents. A second start pulse in mid-conversion shows whether busy-time edges are truly ignored.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;

    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_RUN  = 2'd1,
        SEQ_DONE = 2'd2
    } seq_state_e;

    typedef struct packed {
        logic go;     // accepted start
        logic rise;   // gated clock rising edge this cycle
    } seq_evt_t;

    // bit index decided on rising edge number step (1..nbits)
    function automatic int decide_index(input int step, input int nbits);
        return nbits - step;
    endfunction

endpackage

// File: rtl/sar_edge_det.sv
module sar_edge_det (
    input  logic clk,
    input  logic rst,
    input  logic conv_start,
    output logic start_fall
);
    logic start_q;

    always_ff @(posedge clk) begin
        if (rst) start_q <= 1'b0;
        else     start_q <= conv_start;
    end

    assign start_fall = start_q & ~conv_start;
endmodule

// File: rtl/sar_gclk_gen.sv
module sar_gclk_gen #(
    parameter int HALF_DIV = 100
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic restart,
    output logic gclk,
    output logic rise
);
    localparam int CNT_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(HALF_DIV - 1);

    logic [CNT_W-1:0] cnt_q;
    logic             gclk_q;

    always_ff @(posedge clk) begin
        if (rst || restart || !run) begin
            cnt_q  <= '0;
            gclk_q <= 1'b0;
        end else if (cnt_q == CNT_LAST) begin
            cnt_q  <= '0;
            gclk_q <= ~gclk_q;
        end else begin
            cnt_q  <= cnt_q + 1'b1;
        end
    end

    assign gclk = gclk_q;
    assign rise = run && !restart && !gclk_q && (cnt_q == CNT_LAST);

    p_halt_low_r6: assert property (@(posedge clk) disable iff (rst)
        !run |=> !gclk_q);
endmodule

// File: rtl/sar_ctrl.sv
module sar_ctrl
    import sar_seq_pkg::*;
#(
    parameter int NBITS  = 16,
    parameter int STEP_W = $clog2(NBITS + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_fall,
    input  logic              rise,
    output seq_evt_t          evt,
    output logic              busy,
    output logic              run,
    output logic [STEP_W-1:0] step
);
    localparam logic [STEP_W-1:0] STEP_LAST = STEP_W'(NBITS);

    seq_state_e        state_q;
    logic [STEP_W-1:0] step_q;

    assign evt.go   = start_fall && (state_q == SEQ_IDLE);
    assign evt.rise = rise && (state_q == SEQ_RUN);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SEQ_IDLE;
            step_q  <= '0;
        end else begin
            unique case (state_q)
                SEQ_IDLE: if (evt.go) begin
                    state_q <= SEQ_RUN;
                    step_q  <= '0;
                end
                SEQ_RUN: if (evt.rise) begin
                    if (step_q == STEP_LAST) state_q <= SEQ_DONE;
                    else                     step_q  <= step_q + 1'b1;
                end
                SEQ_DONE: state_q <= SEQ_IDLE;
                default:  state_q <= SEQ_IDLE;
            endcase
        end
    end

    assign busy = (state_q != SEQ_IDLE);
    assign run  = (state_q == SEQ_RUN);
    assign step = step_q;

    p_start_ignored_r7: assert property (@(posedge clk) disable iff (rst)
        (state_q == SEQ_RUN && start_fall && !rise) |=> (state_q == SEQ_RUN && $stable(step_q)));
    p_step_bound_r3: assert property (@(posedge clk) disable iff (rst)
        step_q <= STEP_LAST);
    p_last_edge_r3: assert property (@(posedge clk) disable iff (rst)
        (evt.rise && step_q == STEP_LAST) |=> (state_q == SEQ_DONE));
endmodule

// File: rtl/sar_bit_reg.sv
module sar_bit_reg
    import sar_seq_pkg::*;
#(
    parameter int NBITS  = 16,
    parameter int STEP_W = $clog2(NBITS + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  seq_evt_t          evt,
    input  logic [STEP_W-1:0] step,
    input  logic              cmp_s,
    output logic [NBITS-1:0]  sar
);
    localparam logic [NBITS-1:0] FIRST_TRIAL = {1'b0, {(NBITS-1){1'b1}}};

    logic [NBITS-1:0] sar_q;

    for (genvar gi = 0; gi < NBITS; gi++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst || evt.go) begin
                sar_q[gi] <= 1'b1;
            end else if (evt.rise) begin
                if (step == '0)
                    sar_q[gi] <= (gi != NBITS - 1);
                else if (gi == decide_index(int'(step), NBITS))
                    sar_q[gi] <= cmp_s;
                else if (gi == decide_index(int'(step), NBITS) - 1)
                    sar_q[gi] <= 1'b0;
            end
        end
    end

    assign sar = sar_q;

    p_init_ones_r2: assert property (@(posedge clk) disable iff (rst)
        evt.go |=> (&sar_q));
    p_first_trial_r4: assert property (@(posedge clk) disable iff (rst)
        (evt.rise && step == '0) |=> (sar_q == FIRST_TRIAL));
endmodule

// File: rtl/sar_seq_ctrl.sv
module sar_seq_ctrl
    import sar_seq_pkg::*;
#(
    parameter int NBITS    = 16,
    parameter int HALF_DIV = 100
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             conv_start,
    input  logic             cmp_in,
    input  logic             twos_mode,
    output logic [NBITS-1:0] trial,
    output logic             busy,
    output logic             gclk,
    output logic [NBITS-1:0] result
);
    localparam int STEP_W = $clog2(NBITS + 1);

    logic              start_fall;
    logic              rise;
    logic              run;
    logic              cmp_s;
    logic [STEP_W-1:0] step;
    logic [NBITS-1:0]  sar;
    seq_evt_t          evt;

    // comparator taken one system clock ahead of each gated rising edge
    always_ff @(posedge clk) begin
        if (rst) cmp_s <= 1'b0;
        else     cmp_s <= cmp_in;
    end

    sar_edge_det u_edge (
        .clk        (clk),
        .rst        (rst),
        .conv_start (conv_start),
        .start_fall (start_fall)
    );

    sar_ctrl #(.NBITS(NBITS), .STEP_W(STEP_W)) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .start_fall (start_fall),
        .rise       (rise),
        .evt        (evt),
        .busy       (busy),
        .run        (run),
        .step       (step)
    );

    sar_gclk_gen #(.HALF_DIV(HALF_DIV)) u_gclk (
        .clk     (clk),
        .rst     (rst),
        .run     (run),
        .restart (evt.go),
        .gclk    (gclk),
        .rise    (rise)
    );

    sar_bit_reg #(.NBITS(NBITS), .STEP_W(STEP_W)) u_reg (
        .clk   (clk),
        .rst   (rst),
        .evt   (evt),
        .step  (step),
        .cmp_s (cmp_s),
        .sar   (sar)
    );

    assign trial  = sar;
    assign result = sar ^ {twos_mode, {(NBITS-1){1'b0}}};

    p_gclk_idle_low_r6: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !gclk);
    p_data_stable_r8: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> $stable(sar));
    p_update_on_edge_r5: assert property (@(posedge clk) disable iff (rst)
        (sar != $past(sar)) |-> ($rose(gclk) || $rose(busy)));
endmodule

// File: tb/test_sar_seq_ctrl.sv
`timescale 1ns/1ps
module test_sar_seq_ctrl;
    localparam int NB   = 16;
    localparam int HALF = 4;
    localparam int BUSY_LEN = 33 * HALF + 1;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          conv_start = 1'b0;
    logic          twos_mode = 1'b0;
    logic [NB-1:0] trial, result;
    logic          busy, gclk, cmp_in;
    logic [NB-1:0] vin = '0;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    logic [NB-1:0] exp_q[$];

    always #2.5 clk = ~clk;

    // comparator model: positive-true trial above input -> reject
    assign cmp_in = ((~trial) > vin);

    sar_seq_ctrl #(.NBITS(NB), .HALF_DIV(HALF)) i_sar_seq_ctrl (
        .clk(clk), .rst(rst), .conv_start(conv_start), .cmp_in(cmp_in),
        .twos_mode(twos_mode), .trial(trial), .busy(busy), .gclk(gclk),
        .result(result)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // monitor: gated clock edges, busy length, result scoreboard
    logic          busy_prev = 1'b0, gclk_prev = 1'b0;
    logic [NB-1:0] res_prev = '0;
    int            rise_cnt = 0, busy_cnt = 0;

    always @(negedge clk) begin
        if (!rst) begin
            if (gclk && !gclk_prev) begin
                if (rise_cnt == 0)
                    check(trial == 16'h7FFF, "R4 first trial", trial, 16'h7FFF);
                else begin
                    automatic int bi = NB - rise_cnt;
                    check(trial[bi] == ~vin[bi], "R5 decided bit", trial[bi], ~vin[bi]);
                    if (bi > 0)
                        check(trial[bi-1] == 1'b0, "R5 next bit cleared", trial[bi-1], 0);
                end
                rise_cnt++;
            end
            if (busy) busy_cnt++;
            if (busy_prev && !busy) begin
                check(rise_cnt == 17, "R3 gated edge count", rise_cnt, 17);
                check(busy_cnt == BUSY_LEN, "R6 busy length", busy_cnt, BUSY_LEN);
                check(result == res_prev, "R8 stable before busy fall", result, res_prev);
                if (exp_q.size() == 0)
                    check(1'b0, "R9 unexpected result", result, 0);
                else begin
                    automatic logic [NB-1:0] e = exp_q.pop_front();
                    check(result == e, "R9/R10 result", result, e);
                end
                rise_cnt = 0;
                busy_cnt = 0;
            end
        end
        busy_prev = busy;
        gclk_prev = gclk;
        res_prev  = result;
    end

    // driver
    task automatic run_conv(input logic [NB-1:0] v, input logic m, input bit disturb);
        logic [NB-1:0] e;
        @(negedge clk);
        vin       = v;
        twos_mode = m;
        e = ~v ^ {m, {(NB-1){1'b0}}};
        exp_q.push_back(e);
        conv_start = 1'b1;
        repeat (3) @(negedge clk);
        conv_start = 1'b0;
        @(negedge clk);
        check(busy == 1'b1, "R2 busy after start", busy, 1);
        check(trial == 16'hFFFF, "R2 trial cleared", trial, 16'hFFFF);
        check(gclk == 1'b0, "R2 gclk low at start", gclk, 0);
        if (disturb) begin
            repeat (20) @(negedge clk);
            conv_start = 1'b1;           // R7: edge during conversion
            repeat (3) @(negedge clk);
            conv_start = 1'b0;
        end
        while (busy) @(negedge clk);
        repeat (8) @(negedge clk);
        check(result == e, "R8 result held", result, e);
        check(gclk == 1'b0, "R6 gclk low idle", gclk, 0);
        check(busy == 1'b0, "R7 no restart", busy, 0);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000) begin
            fails++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=<%0d", cyc, 150000);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check(busy == 1'b0, "R1 reset busy", busy, 0);
        check(gclk == 1'b0, "R1 reset gclk", gclk, 0);
        check(trial == 16'hFFFF, "R1 reset trial", trial, 16'hFFFF);
        check(result == 16'hFFFF, "R1 reset result", result, 16'hFFFF);
        rst = 1'b0;
        repeat (4) @(negedge clk);
        check(busy == 1'b0 && gclk == 1'b0, "R1 idle after reset", {busy, gclk}, 0);

        run_conv(16'h0000, 1'b0, 1'b0);
        run_conv(16'hFFFF, 1'b0, 1'b0);
        run_conv(16'h8000, 1'b0, 1'b0);
        // R10: flipping mode changes the MSB combinationally
        @(negedge clk);
        twos_mode = 1'b1;
        #1;
        check(result == 16'hFFFF, "R10 mode flip", result, 16'hFFFF);
        @(negedge clk);
        twos_mode = 1'b0;
        #1;
        check(result == 16'h7FFF, "R10 mode restore", result, 16'h7FFF);

        run_conv(16'h7FFF, 1'b0, 1'b0);
        run_conv(16'hA5C3, 1'b0, 1'b0);
        run_conv(16'h0001, 1'b0, 1'b0);
        run_conv(16'h8000, 1'b1, 1'b0);
        run_conv(16'h1234, 1'b1, 1'b0);
        run_conv(16'h5A5A, 1'b0, 1'b1);   // R7 disturbed conversion
        run_conv(16'hFFFE, 1'b1, 1'b1);

        repeat (5) @(negedge clk);
        check(exp_q.size() == 0, "R9 all results seen", exp_q.size(), 0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule